// File: doc/BRIEF.md
# TDM Time-Slot Interchange Core

This block is a nonblocking time switch for two serial input streams and two serial output streams. Each stream carries 32 channels of 8 bits per frame. Every incoming channel is turned into a byte and written into a 64x8 data store. The store address is the input stream number and the channel number. A 64x9 connect store holds one entry for each output link and channel.

In connection mode an entry names the input stream and channel that feed its output channel. The entry can also silence that output channel. In message mode the entry holds a byte, and that byte is sent unchanged in every frame until the host changes it. The contents for each output channel are fetched during the timeslot before it is sent, then shifted out MSB first.

A host port gives access to both stores, with one request served per access window. A frame reference input aligns the internal timeslot counter. Frame pulse format detection and the serial host link are outside this block.

The bit clock is the block clock. One serial bit lasts two clocks, one channel lasts 16 clocks and one frame lasts 512 clocks. Each channel time is split into eight access periods of two clocks. The periods are, in order:

- period 0: input write-back for stream 0
- period 1: input write-back for stream 1
- period 2: host access
- period 3: connect read for link 0
- period 4: data read for link 0
- period 5: connect read for link 1
- period 6: host access
- period 7: data read for link 1

Top module: `tsi_core`

## Requirements
- R1: Timing of input channel c. In the clock cycles 16c+2k and 16c+2k+1 after a frame start, stream s carries bit 7-k of channel c, so the MSB comes first. The bit is sampled in the second of its two clocks. The byte is stored at data address {s, c}, where address bit 5 is the stream. A host command 2'b10 reads it back.
- R2: Connection mode routing. A connection-mode entry at connect address {link, channel} routes an input to that output channel. Entry bits 4:0 give the source channel and bit 5 gives the source stream. The host writes such an entry with command 2'b01 and the data byte as the entry.
- R3: Broadcast. One input channel may feed any number of output channels in the same frame, and each of them carries the same byte.
- R4: Message mode. Command 2'b11 stores a byte in message mode. That byte is sent on its output channel in every frame until the entry is rewritten.
- R5: Channel silencing in connection mode. Entry bit 6 set to 1 drives sto_en low for all 16 clocks of that channel. Entry bit 7 has no effect on the output.
- R6: In message mode, bit 6 of the entry is ordinary data. The channel stays enabled.
- R7: Global enable. While out_en is low, sto_en is low on both links whatever the entries say. When out_en returns high, the per-channel settings apply again.
- R8: Connect read. Command 2'b00 returns {mode, byte}, where mode is 1 for message and 0 for connection.
- R9: Output timing. Output channel t, bit 7-k, is on sto during the cycles 16t+2k and 16t+2k+1 after a frame start. sto does not change within a bit. A frame starts in the cycle that follows a cycle with frame_sync high.
- R10: Host handshake. The host holds host_req until host_ack. host_ack is a single-cycle pulse and comes within 16 cycles. host_rdata is valid while host_ack is high.
- R11: Reset. After synchronous reset, sto_en is low on both links and host_ack is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High in the last cycle of a frame; the next cycle is channel 0 |
| sti | input | 2 | Serial input streams, MSB first |
| out_en | input | 1 | Global output enable; low silences both links |
| host_req | input | 1 | Host request, held until host_ack |
| host_cmd | input | 2 | 00 read connect, 01 write connection, 10 read data, 11 write message |
| host_addr | input | 6 | {link or stream, channel} |
| host_wdata | input | 8 | Entry byte for writes |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 9 | Read result, {mode, byte} or {0, data} |
| sto | output | 2 | Serial output streams, MSB first |
| sto_en | output | 2 | Per-link drive enable; low means high impedance |

## Verification
The bench sets all 64 connect entries so that the source stream and channel both vary with the destination. Some destinations share one source, and some entries have bit 7 set. A swapped stream bit or an off-by-one fetch address would therefore put the wrong byte on many channels. Silenced and message channels are placed at channel 0 and channel 31, where a design with the prefetch slot counter off by one, or a missing wrap, would enable or fill the wrong neighbour. A message byte with bit 6 set checks that a design does not treat that bit as the silence flag outside connection mode. Turning the global enable off and on checks both the override and the restore.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Byte width; also the number of bit periods per timeslot
  localparam int DW    = 8;
  // Output links and input streams
  localparam int LINKS = 2;

  typedef enum logic [1:0] {
    CMD_RD_CM   = 2'b00,
    CMD_WR_CONN = 2'b01,
    CMD_RD_DM   = 2'b10,
    CMD_WR_MSG  = 2'b11
  } host_cmd_e;
endpackage

// File: rtl/tsi_seq.sv
// Frame position counter: {slot, bit period, half}
module tsi_seq #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_sync,
  output logic [CH_W-1:0] slot,
  output logic [2:0]      per,
  output logic            half
);
  localparam int CW = CH_W + 4;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || frame_sync) cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end

  assign half = cnt[0];
  assign per  = cnt[3:1];
  assign slot = cnt[CW-1:4];
endmodule

// File: rtl/tsi_ram.sv
// Single-port synchronous RAM, read-first, block RAM style
module tsi_ram #(
  parameter int W = 8,
  parameter int A = 6
) (
  input  logic         clk,
  input  logic         en,
  input  logic         we,
  input  logic [A-1:0] addr,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  localparam int DEPTH = 1 << A;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/tsi_rx.sv
// Serial-to-parallel for one input stream
module tsi_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sti,
  input  logic          sample,
  input  logic          last,
  output logic [DW-1:0] hold
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      hold <= '0;
    end else if (sample) begin
      sh <= {sh[DW-2:0], sti};
      if (last) hold <= {sh[DW-2:0], sti};
    end
  end
endmodule

// File: rtl/tsi_tx.sv
// Parallel-to-serial for one output link, MSB first
module tsi_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift,
  input  logic          load,
  input  logic [DW-1:0] ld_byte,
  input  logic          ld_oe,
  output logic          sto,
  output logic          oe
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      oe <= 1'b0;
    end else if (load) begin
      sh <= ld_byte;
      oe <= ld_oe;
    end else if (shift) begin
      sh <= {sh[DW-2:0], 1'b0};
    end
  end

  assign sto = sh[DW-1];
endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_sync,
  input  logic [LINKS-1:0] sti,
  input  logic             out_en,
  input  logic             host_req,
  input  logic [1:0]       host_cmd,
  input  logic [CH_W:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_ack,
  output logic [DW:0]      host_rdata,
  output logic [LINKS-1:0] sto,
  output logic [LINKS-1:0] sto_en
);
  localparam int AW      = CH_W + 1;
  localparam int EW      = DW + 1;
  localparam int TRI_BIT = CH_W + 1;
  localparam int MODE    = DW;

  logic [CH_W-1:0] slot, nxt_slot, hold_slot;
  logic [2:0]      per;
  logic            half, last;

  tsi_seq #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .frame_sync(frame_sync),
    .slot(slot), .per(per), .half(half)
  );

  assign last     = (per == 3'd7) && half;
  assign nxt_slot = slot + CH_W'(1);

  // Input deserialisers
  logic [DW-1:0] rx_byte [LINKS];
  for (genvar s = 0; s < LINKS; s++) begin : g_rx
    tsi_rx #(.DW(DW)) u_rx (
      .clk(clk), .rst(rst), .sti(sti[s]), .sample(half), .last(last),
      .hold(rx_byte[s])
    );
  end

  // Host request holding register
  logic            pend, exec, exec_dm;
  host_cmd_e       p_cmd;
  logic [AW-1:0]   p_addr;
  logic [DW-1:0]   p_wdata;
  logic            win;

  assign win = pend && !half && (per == 3'd2 || per == 3'd6);

  // Memory ports
  logic          dm_en, dm_we;
  logic [AW-1:0] dm_addr;
  logic [DW-1:0] dm_wd, dm_q;
  logic          cm_en, cm_we;
  logic [AW-1:0] cm_addr;
  logic [EW-1:0] cm_wd, cm_q;
  logic [EW-1:0] ent [LINKS];
  logic [DW-1:0] nxt0;

  always_comb begin
    dm_en   = 1'b0;
    dm_we   = 1'b0;
    dm_addr = '0;
    dm_wd   = '0;
    case (per)
      3'd0, 3'd1: begin
        dm_en   = !half;
        dm_we   = !half;
        dm_addr = {per[0], hold_slot};
        dm_wd   = rx_byte[per[0]];
      end
      3'd4: begin
        dm_en   = !half;
        dm_addr = ent[0][AW-1:0];
      end
      3'd7: begin
        dm_en   = !half;
        dm_addr = ent[1][AW-1:0];
      end
      3'd2, 3'd6: begin
        if (pend && p_cmd == CMD_RD_DM) begin
          dm_en   = !half;
          dm_addr = p_addr;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    cm_en   = 1'b0;
    cm_we   = 1'b0;
    cm_addr = '0;
    cm_wd   = '0;
    case (per)
      3'd3: begin
        cm_en   = !half;
        cm_addr = {1'b0, nxt_slot};
      end
      3'd5: begin
        cm_en   = !half;
        cm_addr = {1'b1, nxt_slot};
      end
      3'd2, 3'd6: begin
        if (pend && p_cmd != CMD_RD_DM) begin
          cm_en   = !half;
          cm_we   = !half && (p_cmd == CMD_WR_CONN || p_cmd == CMD_WR_MSG);
          cm_addr = p_addr;
          cm_wd   = {p_cmd == CMD_WR_MSG, p_wdata};
        end
      end
      default: ;
    endcase
  end

  tsi_ram #(.W(DW), .A(AW)) u_dm (
    .clk(clk), .en(dm_en), .we(dm_we), .addr(dm_addr), .wd(dm_wd), .q(dm_q)
  );

  tsi_ram #(.W(EW), .A(AW)) u_cm (
    .clk(clk), .en(cm_en), .we(cm_we), .addr(cm_addr), .wd(cm_wd), .q(cm_q)
  );

  // Sequencing registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      exec       <= 1'b0;
      exec_dm    <= 1'b0;
      p_cmd      <= CMD_RD_CM;
      p_addr     <= '0;
      p_wdata    <= '0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      hold_slot  <= '0;
      nxt0       <= '0;
      for (int l = 0; l < LINKS; l++) ent[l] <= '0;
    end else begin
      host_ack <= 1'b0;
      if (!pend && host_req) begin
        pend    <= 1'b1;
        p_cmd   <= host_cmd_e'(host_cmd);
        p_addr  <= host_addr;
        p_wdata <= host_wdata;
      end
      if (win) begin
        exec    <= 1'b1;
        exec_dm <= (p_cmd == CMD_RD_DM);
      end
      if (exec) begin
        exec     <= 1'b0;
        pend     <= 1'b0;
        host_ack <= 1'b1;
        if (exec_dm)                host_rdata <= {1'b0, dm_q};
        else if (p_cmd == CMD_RD_CM) host_rdata <= cm_q;
        else                        host_rdata <= '0;
      end
      if (last) hold_slot <= slot;
      if (half && per == 3'd3) ent[0] <= cm_q;
      if (half && per == 3'd5) ent[1] <= cm_q;
      if (half && per == 3'd4) nxt0   <= dm_q;
    end
  end

  // Output serialisers
  logic [LINKS-1:0] tx_oe;
  for (genvar l = 0; l < LINKS; l++) begin : g_tx
    logic [DW-1:0] sw_b, ld_b;
    logic          ld_oe;
    if (l == 0) begin : g_buf
      assign sw_b = nxt0;
    end else begin : g_direct
      assign sw_b = dm_q;
    end
    assign ld_b  = ent[l][MODE] ? ent[l][DW-1:0] : sw_b;
    assign ld_oe = ent[l][MODE] | ~ent[l][TRI_BIT];

    tsi_tx #(.DW(DW)) u_tx (
      .clk(clk), .rst(rst), .shift(half), .load(last),
      .ld_byte(ld_b), .ld_oe(ld_oe), .sto(sto[l]), .oe(tx_oe[l])
    );
  end

  assign sto_en = tx_oe & {LINKS{out_en}};
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int LINKS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             host_req,
  input logic             host_ack,
  input logic             out_en,
  input logic [LINKS-1:0] sto,
  input logic [LINKS-1:0] sto_en,
  input logic [2:0]       per,
  input logic             half
);
  // R10: completion is a single pulse
  p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  // R10: a completion always answers a request
  p_ack_had_req_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(host_ack) |-> $past(host_req));

  // R10: completions arrive only right after an access window
  p_ack_window_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> (!half && (per == 3'd3 || per == 3'd7)));

  // R7: global enable low silences both links
  p_global_off_r7: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> (sto_en == '0));

  // R9: serial data holds through the second clock of each bit
  p_bit_hold_r9: assert property (@(posedge clk) disable iff (rst)
    half |-> $stable(sto));

  // R5: per-channel enable changes only at channel boundaries
  p_en_slot_r5: assert property (@(posedge clk) disable iff (rst)
    ((per != 3'd0 || half) && $stable(out_en)) |-> $stable(sto_en));
endmodule

bind tsi_core tsi_core_chk #(.LINKS(tsi_pkg::LINKS)) u_chk (
  .clk(clk), .rst(rst), .host_req(host_req), .host_ack(host_ack),
  .out_en(out_en), .sto(sto), .sto_en(sto_en), .per(per), .half(half)
);

// File: tb/test_tsi_core.sv
module test_tsi_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_sync = 1'b0;
  logic [1:0] sti = '0;
  logic       out_en = 1'b1;
  logic       host_req = 1'b0;
  logic [1:0] host_cmd = '0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_ack;
  logic [8:0] host_rdata;
  logic [1:0] sto, sto_en;

  int n_chk = 0;
  int n_fail = 0;

  tsi_core i_tsi_core (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .sti(sti), .out_en(out_en),
    .host_req(host_req), .host_cmd(host_cmd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .sto(sto), .sto_en(sto_en)
  );

  always #4 clk = ~clk;

  // Bench frame position
  logic [8:0] bcnt;
  always @(posedge clk) begin
    if (rst) bcnt <= '0;
    else     bcnt <= bcnt + 9'd1;
  end

  function automatic logic [7:0] pat(input int s, input int c);
    return 8'((s * 32 + c) * 3 + 7);
  endfunction

  // Input stimulus: MSB first, two clocks per bit (R1)
  always @(negedge clk) begin
    frame_sync = (bcnt == 9'd511);
    for (int s = 0; s < 2; s++) begin
      logic [7:0] b;
      b = pat(s, int'(bcnt[8:4]));
      sti[s] = b[3'd7 - bcnt[3:1]];
    end
  end

  // Model of connect entries
  logic       exp_msg [2][32];
  logic [7:0] exp_ent [2][32];
  logic [7:0] got     [2][32];
  logic       en_all  [2][32];
  logic       en_any  [2][32];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic host_op(input logic [1:0] cmd, input logic [5:0] addr,
                         input logic [7:0] wd, output logic [8:0] rd);
    int waited = 0;
    @(negedge clk);
    host_req = 1'b1; host_cmd = cmd; host_addr = addr; host_wdata = wd;
    do begin
      @(negedge clk);
      waited++;
    end while (!host_ack && waited < 40);
    rd = host_rdata;
    host_req = 1'b0;
    check(waited <= 16, "R10", "ack latency", waited, 16);
  endtask

  task automatic set_conn(input int l, input int c, input int s, input int src,
                          input bit tri_b, input bit b7);
    logic [8:0] rd;
    logic [7:0] e;
    e = {b7, tri_b, 1'(s), 5'(src)};
    host_op(2'b01, {1'(l), 5'(c)}, e, rd);
    exp_msg[l][c] = 1'b0;
    exp_ent[l][c] = e;
  endtask

  task automatic set_msg(input int l, input int c, input logic [7:0] b);
    logic [8:0] rd;
    host_op(2'b11, {1'(l), 5'(c)}, b, rd);
    exp_msg[l][c] = 1'b1;
    exp_ent[l][c] = b;
  endtask

  task automatic wait_frames(input int n);
    repeat (n) begin
      do @(negedge clk); while (bcnt != 9'd0);
    end
  endtask

  task automatic cap_frame();
    do @(negedge clk); while (bcnt != 9'd0);
    for (int i = 0; i < 512; i++) begin
      for (int l = 0; l < 2; l++) begin
        int c;
        c = i >> 4;
        if ((i & 15) == 0) begin
          en_all[l][c] = 1'b1;
          en_any[l][c] = 1'b0;
        end
        en_all[l][c] = en_all[l][c] & sto_en[l];
        en_any[l][c] = en_any[l][c] | sto_en[l];
        if (i % 2 == 1) got[l][c][7 - ((i >> 1) % 8)] = sto[l];
      end
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input string req);
    for (int l = 0; l < 2; l++) begin
      for (int c = 0; c < 32; c++) begin
        bit off;
        logic [7:0] e;
        off = !out_en || (!exp_msg[l][c] && exp_ent[l][c][6]);
        e = exp_msg[l][c] ? exp_ent[l][c]
                          : pat(int'(exp_ent[l][c][5]), int'(exp_ent[l][c][4:0]));
        if (off)
          check(!en_any[l][c], req, $sformatf("silent link%0d ch%0d", l, c),
                int'(en_any[l][c]), 0);
        else
          check(en_all[l][c] && got[l][c] == e, req,
                $sformatf("link%0d ch%0d {en,byte}", l, c),
                int'({en_all[l][c], got[l][c]}), int'({1'b1, e}));
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sto_en == 2'b00, "R11", "sto_en in reset", int'(sto_en), 0);
    check(host_ack == 1'b0, "R11", "ack in reset", int'(host_ack), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sto_en == 2'b00, "R11", "sto_en after reset", int'(sto_en), 0);
  endtask

  task automatic t_dm_read();
    logic [8:0] rd;
    int addrs [6] = '{0, 31, 32, 63, 9, 44};
    wait_frames(2);
    foreach (addrs[i]) begin
      host_op(2'b10, 6'(addrs[i]), 8'h00, rd);
      check(rd == {1'b0, pat(addrs[i] >> 5, addrs[i] & 31)}, "R1",
            $sformatf("data store addr %0d", addrs[i]), int'(rd),
            int'({1'b0, pat(addrs[i] >> 5, addrs[i] & 31)}));
    end
  endtask

  task automatic t_switch();
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 32; c++)
        set_conn(l, c, (c + l) & 1, (c * 7 + l * 3) % 32, 1'b0, (c % 3) == 0);
    // R3: broadcast one source to several outputs
    set_conn(0, 5, 1, 12, 1'b0, 1'b0);
    set_conn(1, 9, 1, 12, 1'b0, 1'b1);
    set_conn(1, 20, 1, 12, 1'b0, 1'b0);
    wait_frames(1);
    cap_frame();
    check_frame("R2 R3 R5 R9");
  endtask

  task automatic t_message();
    set_msg(0, 0, 8'h5A);
    set_msg(0, 31, 8'hC3);
    set_msg(1, 7, 8'h40);   // R6: bit 6 is data
    set_msg(1, 31, 8'hFF);
    wait_frames(1);
    cap_frame();
    check_frame("R4 R6");
    cap_frame();
    check_frame("R4 repeat");
  endtask

  task automatic t_tristate();
    set_conn(0, 0, 1, 3, 1'b1, 1'b0);
    set_conn(1, 31, 0, 30, 1'b1, 1'b1);
    set_conn(1, 16, 1, 0, 1'b1, 1'b0);
    set_conn(0, 13, 0, 31, 1'b1, 1'b0);
    wait_frames(1);
    cap_frame();
    check_frame("R5");
  endtask

  task automatic t_global();
    @(negedge clk);
    out_en = 1'b0;
    cap_frame();
    check_frame("R7 off");
    @(negedge clk);
    out_en = 1'b1;
    cap_frame();
    check_frame("R7 restore");
  endtask

  task automatic t_readback();
    logic [8:0] rd;
    int ls [4] = '{0, 1, 0, 1};
    int cs [4] = '{0, 7, 31, 9};
    foreach (ls[i]) begin
      host_op(2'b00, {1'(ls[i]), 5'(cs[i])}, 8'h00, rd);
      check(rd == {exp_msg[ls[i]][cs[i]], exp_ent[ls[i]][cs[i]]}, "R8",
            $sformatf("connect read link%0d ch%0d", ls[i], cs[i]), int'(rd),
            int'({exp_msg[ls[i]][cs[i]], exp_ent[ls[i]][cs[i]]}));
      @(negedge clk);
      check(host_ack == 1'b0, "R10", "ack single cycle", int'(host_ack), 0);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_dm_read();
    t_switch();
    t_message();
    t_tristate();
    t_global();
    t_readback();
    finish_run();
  end
endmodule